// File: doc/BRIEF.md
# Pin Input Debounce and Edge Event Conditioner

This block conditions one input pin. It brings the asynchronous pad level into the clock domain through a short flop chain. It can then filter that level with a debounce window whose length is a power of two in milliseconds. A shared 1 ms tick from elsewhere on the chip paces the window. The filtered level drives an edge detector. The detector raises a one-cycle event for rising edges, falling edges or both, as the pin's control word selects.

The event pulse is meant to set the pin's interrupt status bit in a neighbouring register block. That block also owns register decoding and interrupt aggregation. The control word is consumed here only in the fields this block needs, at the bit positions that the register block writes.

Top module: `pin_conditioner`

## Requirements
- R1: During and right after reset, `level_out` is 0 and `event_pulse` is 0.
- R2: With debounce off (control bit 8 = 0), a pad change shows on `level_out` at the third rising clock edge after it is applied. `event_pulse` rises in that same cycle when the edge type allows it.
- R3: Edge type field control bits 4:3 = 1 gives events on low-to-high transitions of the filtered level only.
- R4: Edge type 2 gives events on high-to-low transitions only.
- R5: Edge type 3 gives an event on every transition in either direction.
- R6: Edge type 0 produces no events at all.
- R7: Each qualifying transition produces exactly one event, one clock cycle long. A level held steady produces no further events, because there is no level-triggered mode.
- R8: With debounce on (bit 8 = 1), the window is 2^code ms, where code is control bits 7:5. `level_out` takes a new synchronized value only after that value has held for the full number of `ms_tick` pulses, and it changes only in a cycle that carries a tick.
- R9: A pad excursion shorter than the window leaves `level_out` unchanged and produces no event.
- R10: A change of the debounce code restarts the window count. Progress made under the old code is discarded, and the level does not change in the cycle of the change.
- R11: Code 0 gives a 1 ms window and code 7 gives a 128 ms window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pad_in | input | 1 | Raw asynchronous pad level |
| ctrl | input | 9 | Pin control word: bits 4:3 edge type, 7:5 debounce code, 8 debounce enable; bits 2:0 unused here |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| level_out | output | 1 | Synchronized and optionally debounced level |
| event_pulse | output | 1 | One-cycle edge event toward the interrupt status bit |

## Verification
The hardest case to reach is a debounce code rewrite while a window is partly counted. The pad must have moved, some ticks must have passed but not enough, and then the code must drop to a value the old count already exceeds. The bench holds the tick divider at a known ratio and moves the pad on a falling clock edge. It waits a cycle count that gives six ticks under an eight-tick window, then switches to a four-tick window. A design that kept the old count would settle within one tick; the bench checks that the level is still old several cycles later. Glitch rejection and the 128 ms extreme are reached with the same counted waits.

// File: rtl/pinc_pkg.sv
package pinc_pkg;
  localparam int CTRL_W    = 9;
  localparam int TYPE_LSB  = 3;
  localparam int CODE_LSB  = 5;
  localparam int DBEN_BIT  = 8;
  localparam int CODE_W    = 3;
  localparam int CNT_W     = 1 << CODE_W;

  typedef logic [CNT_W:0] win_t;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_mode_t;

  // Window length in ticks for a debounce code.
  function automatic win_t window_ticks(input logic [CODE_W-1:0] code);
    window_ticks = win_t'(1) << code;
  endfunction

  // True when a transition qualifies under the selected edge type.
  function automatic logic edge_hit(input edge_mode_t mode, input logic rise, input logic fall);
    case (mode)
      EDGE_RISE: edge_hit = rise;
      EDGE_FALL: edge_hit = fall;
      EDGE_BOTH: edge_hit = rise | fall;
      default:   edge_hit = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/pinc_sync.sv
module pinc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/pinc_debounce.sv
module pinc_debounce
  import pinc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              raw,
  input  logic              en,
  input  logic [CODE_W-1:0] code,
  input  logic              ms_tick,
  output logic              level,
  output logic              window_done,
  output logic              restart_evt
);
  logic              level_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CODE_W-1:0] code_q;
  logic              differ;

  assign differ      = raw != level_q;
  assign restart_evt = code != code_q;
  assign window_done = en && differ && !restart_evt && ms_tick &&
                       ((win_t'(cnt_q) + win_t'(1)) >= window_ticks(code));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      cnt_q   <= '0;
      code_q  <= '0;
    end else begin
      code_q <= code;
      if (!en) begin
        level_q <= raw;
        cnt_q   <= '0;
      end else if (!differ || restart_evt) begin
        cnt_q <= '0;
      end else if (window_done) begin
        level_q <= raw;
        cnt_q   <= '0;
      end else if (ms_tick) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign level = level_q;
endmodule

// File: rtl/pinc_edge.sv
module pinc_edge
  import pinc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       level,
  input  logic [1:0] mode,
  output logic       evt
);
  logic prev_q;
  logic rise;
  logic fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level;
  end

  assign rise = level & ~prev_q;
  assign fall = ~level & prev_q;
  assign evt  = edge_hit(edge_mode_t'(mode), rise, fall);
endmodule

// File: rtl/pin_conditioner.sv
module pin_conditioner
  import pinc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pad_in,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic              ms_tick,
  output logic              level_out,
  output logic              event_pulse
);
  logic              pad_sync;
  logic              window_done;
  logic              restart_evt;
  logic [1:0]        edge_sel;
  logic [CODE_W-1:0] db_code;
  logic              db_en;
  logic              unused_ctrl_bits;

  assign edge_sel         = ctrl[TYPE_LSB +: 2];
  assign db_code          = ctrl[CODE_LSB +: CODE_W];
  assign db_en            = ctrl[DBEN_BIT];
  assign unused_ctrl_bits = ^ctrl[TYPE_LSB-1:0];

  pinc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pad_sync)
  );

  pinc_debounce u_db (
    .clk(clk), .rst_n(rst_n), .raw(pad_sync), .en(db_en), .code(db_code),
    .ms_tick(ms_tick), .level(level_out), .window_done(window_done),
    .restart_evt(restart_evt)
  );

  pinc_edge u_edge (
    .clk(clk), .rst_n(rst_n), .level(level_out), .mode(edge_sel), .evt(event_pulse)
  );
endmodule

// File: rtl/pinc_checker.sv
module pinc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] edge_sel,
  input logic       db_en,
  input logic       ms_tick,
  input logic       level_out,
  input logic       event_pulse,
  input logic       window_done,
  input logic       restart_evt
);
  p_one_cycle_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
    event_pulse |=> !event_pulse);

  p_off_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_sel == 2'd0) |-> !event_pulse);

  p_rise_polarity_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_sel == 2'd1 && event_pulse) |-> level_out);

  p_fall_polarity_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_sel == 2'd2 && event_pulse) |-> !level_out);

  p_tick_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (db_en && $past(db_en) && level_out != $past(level_out)) |-> $past(ms_tick));

  p_done_moves_r8: assert property (@(posedge clk) disable iff (!rst_n)
    window_done |=> !$stable(level_out));

  p_restart_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_evt && db_en) |=> $stable(level_out));
endmodule

bind pin_conditioner pinc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .edge_sel(ctrl[4:3]), .db_en(ctrl[8]),
  .ms_tick(ms_tick), .level_out(level_out), .event_pulse(event_pulse),
  .window_done(window_done), .restart_evt(restart_evt)
);

// File: tb/sim_pin_conditioner.sv
module sim_pin_conditioner;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pad_in = 1'b0;
  logic [8:0] ctrl = '0;
  logic       ms_tick = 1'b0;
  logic       level_out;
  logic       event_pulse;

  int n_tests = 0;
  int n_fail  = 0;
  int ev_cnt  = 0;
  int dbl_cnt = 0;
  int tdiv    = 0;
  logic prev_ev = 1'b0;
  bit finished = 1'b0;

  pin_conditioner u0 (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .ctrl(ctrl),
    .ms_tick(ms_tick), .level_out(level_out), .event_pulse(event_pulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Tick source and event monitor, both away from the rising edge.
  always @(negedge clk) begin
    tdiv    <= (tdiv == TICK_DIV-1) ? 0 : tdiv + 1;
    ms_tick <= (tdiv == TICK_DIV-1);
    if (event_pulse) ev_cnt <= ev_cnt + 1;
    if (event_pulse && prev_ev) dbl_cnt <= dbl_cnt + 1;
    prev_ev <= event_pulse;
  end

  function automatic logic [8:0] mk_ctrl(input logic en, input logic [2:0] code, input logic [1:0] mode);
    mk_ctrl = {en, code, mode, 3'b000};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic settle_low();
    ctrl   = mk_ctrl(1'b0, 3'd0, 2'd0);
    pad_in = 1'b0;
    wait_neg(6);
    ev_cnt = 0;
    dbl_cnt = 0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    wait_neg(3);
    check(level_out == 1'b0, "R1 level in reset", level_out, 0);
    check(event_pulse == 1'b0, "R1 event in reset", event_pulse, 0);
    rst_n = 1'b1;
    wait_neg(2);
    check(level_out == 1'b0 && event_pulse == 1'b0, "R1 after release", level_out, 0);
  endtask

  task automatic t_latency();
    settle_low();
    ctrl = mk_ctrl(1'b0, 3'd0, 2'd3);
    @(negedge clk);
    pad_in = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    check(level_out == 1'b0, "R2 level before third edge", level_out, 0);
    @(posedge clk); #1;
    check(level_out == 1'b1, "R2 level at third edge", level_out, 1);
    check(event_pulse == 1'b1, "R2 event at third edge", event_pulse, 1);
    @(posedge clk); #1;
    check(event_pulse == 1'b0, "R7 event one cycle", event_pulse, 0);
    wait_neg(20);
    check(ev_cnt == 1, "R7 held level no repeat", ev_cnt, 1);
    check(dbl_cnt == 0, "R7 no back-to-back", dbl_cnt, 0);
  endtask

  task automatic t_mode(input logic [1:0] mode, input int exp_cnt, input string tag);
    settle_low();
    ctrl = mk_ctrl(1'b0, 3'd0, mode);
    wait_neg(2);
    ev_cnt = 0;
    pad_in = 1'b1; wait_neg(8);
    pad_in = 1'b0; wait_neg(8);
    pad_in = 1'b1; wait_neg(8);
    pad_in = 1'b0; wait_neg(8);
    check(ev_cnt == exp_cnt, tag, ev_cnt, exp_cnt);
    check(dbl_cnt == 0, "R7 single-cycle events", dbl_cnt, 0);
  endtask

  task automatic t_window8();
    settle_low();
    ctrl = mk_ctrl(1'b1, 3'd3, 2'd1);
    wait_neg(4);
    ev_cnt = 0;
    pad_in = 1'b1;
    wait_neg(20);
    check(level_out == 1'b0, "R8 code 3 not early", level_out, 0);
    check(ev_cnt == 0, "R8 no early event", ev_cnt, 0);
    wait_neg(24);
    check(level_out == 1'b1, "R8 code 3 settled", level_out, 1);
    check(ev_cnt == 1, "R8 one event after window", ev_cnt, 1);
  endtask

  task automatic t_glitch();
    settle_low();
    ctrl = mk_ctrl(1'b1, 3'd2, 2'd3);
    wait_neg(4);
    ev_cnt = 0;
    pad_in = 1'b1;
    wait_neg(8);
    pad_in = 1'b0;
    wait_neg(40);
    check(level_out == 1'b0, "R9 glitch rejected", level_out, 0);
    check(ev_cnt == 0, "R9 glitch no event", ev_cnt, 0);
  endtask

  task automatic t_restart();
    settle_low();
    ctrl = mk_ctrl(1'b1, 3'd3, 2'd3);
    wait_neg(4);
    ev_cnt = 0;
    pad_in = 1'b1;
    wait_neg(26);
    check(level_out == 1'b0, "R10 before code change", level_out, 0);
    ctrl = mk_ctrl(1'b1, 3'd2, 2'd3);
    wait_neg(9);
    check(level_out == 1'b0, "R10 count restarted", level_out, 0);
    wait_neg(20);
    check(level_out == 1'b1, "R10 settles on new window", level_out, 1);
    check(ev_cnt == 1, "R10 single event", ev_cnt, 1);
  endtask

  task automatic t_extremes();
    settle_low();
    ctrl = mk_ctrl(1'b1, 3'd0, 2'd3);
    wait_neg(4);
    pad_in = 1'b1;
    wait_neg(12);
    check(level_out == 1'b1, "R11 code 0 one tick", level_out, 1);
    ctrl = mk_ctrl(1'b1, 3'd7, 2'd3);
    wait_neg(4);
    ev_cnt = 0;
    pad_in = 1'b0;
    wait_neg(490);
    check(level_out == 1'b1, "R11 code 7 not early", level_out, 1);
    wait_neg(50);
    check(level_out == 1'b0, "R11 code 7 settled", level_out, 0);
    check(ev_cnt == 1, "R11 code 7 one event", ev_cnt, 1);
  endtask

  initial begin
    t_reset();
    t_latency();
    t_mode(2'd1, 2, "R3 rising only");
    t_mode(2'd2, 2, "R4 falling only");
    t_mode(2'd3, 4, "R5 both edges");
    t_mode(2'd0, 0, "R6 type off");
    t_window8();
    t_glitch();
    t_restart();
    t_extremes();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule